// File: doc/BRIEF.md
# Three-State Snooping Coherence Controller

This block keeps a small direct-mapped, write-back cache coherent with its peers on a shared bus under a write-invalidate scheme. Each line holds a tag, a data word and one of three states: Invalid, Shared, or Exclusive. Shared means the line is clean and read-only. Exclusive means the line is dirty and is the only cached copy. The processor side uses a hold-until-acknowledge handshake. Hits are acknowledged in the same cycle. Misses raise a bus request that completes in the cycle the bus grants it.

A transaction from another master is presented on the snoop inputs during the cycle that master owns the bus. The controller updates the matching line in that cycle. If it holds the line dirty, it drives the line data on the flush outputs, and that data takes the place of the memory reply. Snoops take precedence over processor requests in the same cycle. This keeps every write to a location in the order set by bus grants.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset every line is Invalid (state code 0), so any first processor access produces a bus request and no acknowledge.
- R2: A processor read to a line that does not match raises `bus_req` with `bus_cmd` = 1 (read miss) at the request address. In the granted cycle it acknowledges with `bus_rdata` and leaves the line Shared (code 1).
- R3: A processor write to a line that is Invalid, or Shared with a matching tag, raises `bus_cmd` = 2 (write miss). In the granted cycle it acknowledges and leaves the line Exclusive (code 2) holding `cpu_wdata`.
- R4: A read that matches a Shared or Exclusive line, and a write that matches an Exclusive line, are acknowledged in the request cycle with `bus_req` low.
- R5: A miss to an index whose line is Exclusive under a different tag first requests `bus_cmd` = 3 (write-back). That request carries the old address (old tag, same index) and the line data. Only after it is granted does the controller place the read or write miss for the new address.
- R6: A snooped write miss (`snp_cmd` = 2) that matches a Shared line makes it Invalid, with no flush.
- R7: A snooped read miss (`snp_cmd` = 1) that matches an Exclusive line asserts `snp_flush` with the line data in the same cycle and leaves the line Shared.
- R8: A snooped write miss that matches an Exclusive line asserts `snp_flush` with the line data in the same cycle and leaves the line Invalid.
- R9: A snoop whose tag does not match the stored tag, or that finds the line Invalid, or that is a read miss on a Shared line, changes no state and does not flush.
- R10: In a cycle with `snp_valid` high, `cpu_ack` stays low and no processor-side state change happens. The processor request is served in a later cycle against the state the snoop left.
- R11: A read hit returns the stored word, a read miss returns `bus_rdata`, and a write hit or write miss replaces the stored word with `cpu_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address; low INDEX_W bits select the line |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ack | output | 1 | Request completed this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ack on a read |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus granted; the transaction completes this cycle |
| bus_cmd | output | 2 | 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | ADDR_W | Address of the bus transaction |
| bus_wdata | output | DATA_W | Data written back on command 3 |
| bus_rdata | input | DATA_W | Fill data on a granted miss |
| snp_valid | input | 1 | Another master's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same codes as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_flush | output | 1 | Dirty copy supplied; memory reply is aborted |
| snp_flush_data | output | DATA_W | Dirty line data |

## Verification
The bench builds the controller with ADDR_W = 4, INDEX_W = 2 and DATA_W = 8, which gives four lines and four tags per line. With so few lines, replacements of dirty lines and tag mismatches on snoops occur constantly. The directed part walks every state through every processor and snoop event. A long pseudo-random sweep then mixes reads, writes and snoops over all sixteen addresses, and a bench model of tags, states and memory predicts every bus transaction, flush and read value. A same-cycle snoop against a processor hit on the same line shows the ordering rule directly.

// File: rtl/coh_pkg.sv
package coh_pkg;
   typedef enum logic [1:0] {
      LS_INV = 2'd0,
      LS_SHR = 2'd1,
      LS_EXC = 2'd2
   } line_st_e;

   typedef enum logic [1:0] {
      BC_IDLE   = 2'd0,
      BC_RDMISS = 2'd1,
      BC_WRMISS = 2'd2,
      BC_WBACK  = 2'd3
   } bus_cmd_e;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
   import coh_pkg::*;
#(
   parameter int INDEX_W = 2,
   parameter int TAG_W   = 6,
   parameter int DATA_W  = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [INDEX_W-1:0]   a_idx,
   output logic [TAG_W-1:0]     a_tag,
   output line_st_e             a_st,
   output logic [DATA_W-1:0]    a_data,
   input  logic [INDEX_W-1:0]   b_idx,
   output logic [TAG_W-1:0]     b_tag,
   output line_st_e             b_st,
   output logic [DATA_W-1:0]    b_data,
   input  logic                 w_en,
   input  logic [INDEX_W-1:0]   w_idx,
   input  logic [TAG_W-1:0]     w_tag,
   input  line_st_e             w_st,
   input  logic [DATA_W-1:0]    w_data,
   output logic [2*(1<<INDEX_W)-1:0] st_flat
);
   localparam int LINES = 1 << INDEX_W;

   logic [TAG_W-1:0]  tag_q  [LINES];
   line_st_e          st_q   [LINES];
   logic [DATA_W-1:0] data_q [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q[g]   <= LS_INV;
            tag_q[g]  <= '0;
            data_q[g] <= '0;
         end else if (w_en && (w_idx == INDEX_W'(g))) begin
            st_q[g]   <= w_st;
            tag_q[g]  <= w_tag;
            data_q[g] <= w_data;
         end
      end
      assign st_flat[2*g +: 2] = st_q[g];
   end

   assign a_tag  = tag_q[a_idx];
   assign a_st   = st_q[a_idx];
   assign a_data = data_q[a_idx];
   assign b_tag  = tag_q[b_idx];
   assign b_st   = st_q[b_idx];
   assign b_data = data_q[b_idx];
endmodule

// File: rtl/coh_decide.sv
module coh_decide
   import coh_pkg::*;
#(
   parameter int INDEX_W = 2,
   parameter int TAG_W   = 6,
   parameter int DATA_W  = 32
) (
   input  logic                cpu_req,
   input  logic                cpu_we,
   input  logic [TAG_W-1:0]    cpu_tag,
   input  logic [INDEX_W-1:0]  cpu_idx,
   input  logic [DATA_W-1:0]   cpu_wdata,
   input  logic                snp_valid,
   input  logic [1:0]          snp_cmd,
   input  logic [TAG_W-1:0]    snp_tag,
   input  logic [INDEX_W-1:0]  snp_idx,
   input  logic                bus_gnt,
   input  logic [DATA_W-1:0]   bus_rdata,
   input  logic [TAG_W-1:0]    a_tag,
   input  line_st_e            a_st,
   input  logic [DATA_W-1:0]   a_data,
   input  logic [TAG_W-1:0]    b_tag,
   input  line_st_e            b_st,
   input  logic [DATA_W-1:0]   b_data,
   output logic                cpu_ack,
   output logic [DATA_W-1:0]   cpu_rdata,
   output logic                bus_req,
   output bus_cmd_e            bus_cmd,
   output logic [TAG_W-1:0]    bus_tag,
   output logic [DATA_W-1:0]   bus_wdata,
   output logic                snp_flush,
   output logic [DATA_W-1:0]   snp_flush_data,
   output logic                w_en,
   output logic [INDEX_W-1:0]  w_idx,
   output logic [TAG_W-1:0]    w_tag,
   output line_st_e            w_st,
   output logic [DATA_W-1:0]   w_data
);
   logic cpu_hit, victim, snp_match, snp_rd, snp_wr;

   always_comb begin
      cpu_hit   = (a_st != LS_INV) && (a_tag == cpu_tag) && (!cpu_we || a_st == LS_EXC);
      victim    = (a_st == LS_EXC) && (a_tag != cpu_tag);
      snp_match = snp_valid && (b_st != LS_INV) && (b_tag == snp_tag);
      snp_rd    = (snp_cmd == BC_RDMISS);
      snp_wr    = (snp_cmd == BC_WRMISS);

      cpu_ack        = 1'b0;
      cpu_rdata      = a_data;
      bus_req        = 1'b0;
      bus_cmd        = BC_IDLE;
      bus_tag        = cpu_tag;
      bus_wdata      = a_data;
      snp_flush      = 1'b0;
      snp_flush_data = b_data;
      w_en           = 1'b0;
      w_idx          = cpu_idx;
      w_tag          = a_tag;
      w_st           = a_st;
      w_data         = a_data;

      // bus request does not look at the snoop inputs: no loop through the arbiter
      if (cpu_req && !cpu_hit) begin
         bus_req = 1'b1;
         if (victim) begin
            bus_cmd = BC_WBACK;
            bus_tag = a_tag;
         end else begin
            bus_cmd = cpu_we ? BC_WRMISS : BC_RDMISS;
         end
      end

      if (snp_valid) begin
         w_idx  = snp_idx;
         w_tag  = b_tag;
         w_data = b_data;
         w_st   = b_st;
         if (snp_match && b_st == LS_EXC && (snp_rd || snp_wr)) begin
            snp_flush = 1'b1;
            w_en      = 1'b1;
            w_st      = snp_rd ? LS_SHR : LS_INV;
         end else if (snp_match && b_st == LS_SHR && snp_wr) begin
            w_en = 1'b1;
            w_st = LS_INV;
         end
      end else if (cpu_req) begin
         if (cpu_hit) begin
            cpu_ack = 1'b1;
            if (cpu_we) begin
               w_en   = 1'b1;
               w_data = cpu_wdata;
               w_st   = LS_EXC;
            end
         end else if (bus_gnt) begin
            w_en = 1'b1;
            if (victim) begin
               w_st = LS_INV;
            end else begin
               cpu_ack   = 1'b1;
               cpu_rdata = bus_rdata;
               w_tag     = cpu_tag;
               w_st      = cpu_we ? LS_EXC : LS_SHR;
               w_data    = cpu_we ? cpu_wdata : bus_rdata;
            end
         end
      end
   end
endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl
   import coh_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int INDEX_W = 2,
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ack,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              snp_valid,
   input  logic [1:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_flush,
   output logic [DATA_W-1:0] snp_flush_data
);
   localparam int LINES = 1 << INDEX_W;
   localparam int TAG_W = ADDR_W - INDEX_W;

   if (INDEX_W < 1 || INDEX_W > 6) begin : g_bad_index
      $error("INDEX_W must lie in 1..6");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W must exceed INDEX_W");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic [TAG_W-1:0]   a_tag, b_tag, w_tag, bus_tag;
   line_st_e           a_st, b_st, w_st;
   logic [DATA_W-1:0]  a_data, b_data, w_data;
   logic               w_en;
   logic [INDEX_W-1:0] w_idx;
   bus_cmd_e           cmd_e;
   logic [2*LINES-1:0] line_st_flat;

   coh_line_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .a_idx  (cpu_addr[INDEX_W-1:0]),
      .a_tag  (a_tag),
      .a_st   (a_st),
      .a_data (a_data),
      .b_idx  (snp_addr[INDEX_W-1:0]),
      .b_tag  (b_tag),
      .b_st   (b_st),
      .b_data (b_data),
      .w_en   (w_en),
      .w_idx  (w_idx),
      .w_tag  (w_tag),
      .w_st   (w_st),
      .w_data (w_data),
      .st_flat(line_st_flat)
   );

   coh_decide #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_decide (
      .cpu_req       (cpu_req),
      .cpu_we        (cpu_we),
      .cpu_tag       (cpu_addr[ADDR_W-1:INDEX_W]),
      .cpu_idx       (cpu_addr[INDEX_W-1:0]),
      .cpu_wdata     (cpu_wdata),
      .snp_valid     (snp_valid),
      .snp_cmd       (snp_cmd),
      .snp_tag       (snp_addr[ADDR_W-1:INDEX_W]),
      .snp_idx       (snp_addr[INDEX_W-1:0]),
      .bus_gnt       (bus_gnt),
      .bus_rdata     (bus_rdata),
      .a_tag         (a_tag),
      .a_st          (a_st),
      .a_data        (a_data),
      .b_tag         (b_tag),
      .b_st          (b_st),
      .b_data        (b_data),
      .cpu_ack       (cpu_ack),
      .cpu_rdata     (cpu_rdata),
      .bus_req       (bus_req),
      .bus_cmd       (cmd_e),
      .bus_tag       (bus_tag),
      .bus_wdata     (bus_wdata),
      .snp_flush     (snp_flush),
      .snp_flush_data(snp_flush_data),
      .w_en          (w_en),
      .w_idx         (w_idx),
      .w_tag         (w_tag),
      .w_st          (w_st),
      .w_data        (w_data)
   );

   assign bus_cmd  = cmd_e;
   assign bus_addr = {bus_tag, cpu_addr[INDEX_W-1:0]};
endmodule

// File: rtl/coh_checker.sv
module coh_checker #(
   parameter int ADDR_W  = 8,
   parameter int INDEX_W = 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      cpu_req,
   input logic [ADDR_W-1:0]         cpu_addr,
   input logic                      cpu_ack,
   input logic                      bus_req,
   input logic                      bus_gnt,
   input logic [1:0]                bus_cmd,
   input logic [ADDR_W-1:0]         bus_addr,
   input logic                      snp_valid,
   input logic [1:0]                snp_cmd,
   input logic [ADDR_W-1:0]         snp_addr,
   input logic                      snp_flush,
   input logic [2*(1<<INDEX_W)-1:0] line_st
);
   logic [INDEX_W-1:0] cpu_idx_q, snp_idx_q;

   always_ff @(posedge clk) begin
      cpu_idx_q <= cpu_addr[INDEX_W-1:0];
      snp_idx_q <= snp_addr[INDEX_W-1:0];
   end

   function automatic logic [1:0] st_of(input logic [INDEX_W-1:0] i);
      return line_st[2*int'(i) +: 2];
   endfunction

   AST_SNOOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid |-> !cpu_ack); // R10
   AST_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack && !bus_gnt) |-> !bus_req); // R4
   AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |-> cpu_req); // R4
   AST_FLUSH_ON_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
      snp_flush |-> (snp_valid && (snp_cmd == 2'd1 || snp_cmd == 2'd2))); // R7
   AST_WB_OLD_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_cmd == 2'd3) |->
         (bus_addr[INDEX_W-1:0] == cpu_addr[INDEX_W-1:0] &&
          bus_addr[ADDR_W-1:INDEX_W] != cpu_addr[ADDR_W-1:INDEX_W])); // R5
   AST_RDMISS_SHR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_gnt && bus_cmd == 2'd1 && !snp_valid) |=> (st_of(cpu_idx_q) == 2'd1)); // R2
   AST_WRMISS_EXC: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_gnt && bus_cmd == 2'd2 && !snp_valid) |=> (st_of(cpu_idx_q) == 2'd2)); // R3
   AST_SNPRD_SHR: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_flush && snp_cmd == 2'd1) |=> (st_of(snp_idx_q) == 2'd1)); // R7
   AST_SNPWR_INV: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_flush && snp_cmd == 2'd2) |=> (st_of(snp_idx_q) == 2'd0)); // R8
endmodule

bind snoop_coh_ctrl coh_checker #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W)) u_coh_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .cpu_req  (cpu_req),
   .cpu_addr (cpu_addr),
   .cpu_ack  (cpu_ack),
   .bus_req  (bus_req),
   .bus_gnt  (bus_gnt),
   .bus_cmd  (bus_cmd),
   .bus_addr (bus_addr),
   .snp_valid(snp_valid),
   .snp_cmd  (snp_cmd),
   .snp_addr (snp_addr),
   .snp_flush(snp_flush),
   .line_st  (line_st_flat)
);

// File: tb/snoop_coh_ctrl_bench.sv
module snoop_coh_ctrl_bench;
   localparam int AW = 4;
   localparam int IW = 2;
   localparam int DW = 8;
   localparam int NL = 1 << IW;
   localparam int NA = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_ack;
   logic [DW-1:0] cpu_rdata;
   logic          bus_req;
   logic          bus_gnt = 1'b0;
   logic [1:0]    bus_cmd;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic [DW-1:0] bus_rdata = '0;
   logic          snp_valid = 1'b0;
   logic [1:0]    snp_cmd = 2'd0;
   logic [AW-1:0] snp_addr = '0;
   logic          snp_flush;
   logic [DW-1:0] snp_flush_data;

   int checks = 0;
   int failures = 0;

   // reference model: 0 Invalid, 1 Shared, 2 Exclusive
   int            m_st   [NL];
   logic [AW-IW-1:0] m_tag [NL];
   logic [DW-1:0] m_data [NL];
   logic [DW-1:0] mem    [NA];

   always #5 clk = ~clk;

   snoop_coh_ctrl #(.ADDR_W(AW), .INDEX_W(IW), .DATA_W(DW)) u_snoop_coh_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
      .snp_flush(snp_flush), .snp_flush_data(snp_flush_data)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   // processor access with bench acting as the bus arbiter and memory
   task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd);
      int idx = int'(a[IW-1:0]);
      logic [AW-IW-1:0] tg = a[AW-1:IW];
      bit hit = (m_st[idx] != 0) && (m_tag[idx] == tg) && (!we || m_st[idx] == 2);
      bit wb  = !hit && (m_st[idx] == 2) && (m_tag[idx] != tg);
      @(posedge clk); #1;
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; bus_gnt = 1'b0;
      #3;
      if (hit) begin
         chk("R4", "hit ack", int'(cpu_ack), 1);
         chk("R4", "hit bus_req", int'(bus_req), 0);
         if (!we) chk("R11", "hit rdata", int'(cpu_rdata), int'(m_data[idx]));
         else m_data[idx] = wd;
      end else begin
         if (wb) begin
            chk("R5", "wb cmd", int'(bus_req) * 4 + int'(bus_cmd), 7);
            chk("R5", "wb addr", int'(bus_addr), int'({m_tag[idx], a[IW-1:0]}));
            chk("R5", "wb data", int'(bus_wdata), int'(m_data[idx]));
            chk("R5", "no ack during wb", int'(cpu_ack), 0);
            bus_gnt = 1'b1;
            #1;
            chk("R5", "no ack on wb grant", int'(cpu_ack), 0);
            mem[{m_tag[idx], a[IW-1:0]}] = m_data[idx];
            m_st[idx] = 0;
            @(posedge clk); #1;
            bus_gnt = 1'b0;
            #3;
         end
         chk(we ? "R3" : "R2", "miss cmd", int'(bus_req) * 4 + int'(bus_cmd), we ? 6 : 5);
         chk(we ? "R3" : "R2", "miss addr", int'(bus_addr), int'(a));
         chk(we ? "R3" : "R2", "no early ack", int'(cpu_ack), 0);
         bus_rdata = mem[a];
         bus_gnt = 1'b1;
         #1;
         chk(we ? "R3" : "R2", "ack on grant", int'(cpu_ack), 1);
         if (!we) chk("R11", "miss rdata", int'(cpu_rdata), int'(mem[a]));
         m_tag[idx] = tg;
         m_st[idx] = we ? 2 : 1;
         m_data[idx] = we ? wd : mem[a];
      end
      @(posedge clk); #1;
      cpu_req = 1'b0; bus_gnt = 1'b0;
   endtask

   task automatic snoop(input logic wr, input logic [AW-1:0] a);
      int idx = int'(a[IW-1:0]);
      bit match = (m_st[idx] != 0) && (m_tag[idx] == a[AW-1:IW]);
      bit dirty = match && (m_st[idx] == 2);
      string req;
      if (dirty) req = wr ? "R8" : "R7";
      else if (match && wr) req = "R6";
      else req = "R9";
      @(posedge clk); #1;
      snp_valid = 1'b1; snp_cmd = wr ? 2'd2 : 2'd1; snp_addr = a;
      #3;
      chk(req, "snoop flush", int'(snp_flush), int'(dirty));
      if (dirty) begin
         chk(req, "flush data", int'(snp_flush_data), int'(m_data[idx]));
         mem[a] = m_data[idx];
         m_st[idx] = wr ? 0 : 1;
      end else if (match && wr) begin
         m_st[idx] = 0;
      end
      @(posedge clk); #1;
      snp_valid = 1'b0; snp_cmd = 2'd0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
      $finish;
   end

   initial begin
      int seed = 32'h1d2c;
      for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_tag[i] = '0; m_data[i] = '0; end
      for (int i = 0; i < NA; i++) mem[i] = DW'(i * 37 + 11);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #3;
      chk("R1", "idle bus_req", int'(bus_req), 0);
      chk("R1", "idle flush", int'(snp_flush), 0);

      // R1: every line misses after reset
      for (int i = 0; i < NL; i++) begin
         @(posedge clk); #1;
         cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = AW'(i + 4 * (i % 3));
         #3;
         chk("R1", "reset miss req", int'(bus_req) * 4 + int'(bus_cmd), 5);
         chk("R1", "reset no ack", int'(cpu_ack), 0);
         @(posedge clk); #1 cpu_req = 1'b0;
      end

      // directed walk through the states
      access(1'b0, 4'd1, 8'h00);  // R2 read miss
      access(1'b0, 4'd1, 8'h00);  // R4 read hit Shared
      access(1'b1, 4'd1, 8'hA1);  // R3 write on Shared is a miss
      access(1'b1, 4'd1, 8'hA2);  // R4 write hit Exclusive
      access(1'b0, 4'd1, 8'h00);  // R4 read hit Exclusive
      access(1'b0, 4'd5, 8'h00);  // R5 write-back then read miss
      access(1'b0, 4'd1, 8'h00);  // R11 written-back data comes from memory
      snoop(1'b0, 4'd1);          // R9 read snoop on Shared
      snoop(1'b1, 4'd1);          // R6 write snoop invalidates
      access(1'b0, 4'd1, 8'h00);  // miss again after R6
      access(1'b1, 4'd2, 8'hB2);
      snoop(1'b0, 4'd2);          // R7 flush, Shared
      access(1'b0, 4'd2, 8'h00);  // R7 still readable
      access(1'b1, 4'd2, 8'hB3);  // R7 line clean: write misses
      access(1'b1, 4'd3, 8'hC3);
      snoop(1'b1, 4'd7);          // R9 tag mismatch on dirty line
      access(1'b0, 4'd3, 8'h00);  // R9 still Exclusive
      snoop(1'b1, 4'd3);          // R8 flush, Invalid
      access(1'b0, 4'd3, 8'h00);  // miss after R8

      // R10: snoop and processor hit in the same cycle, same line
      access(1'b1, 4'd0, 8'hD0);
      @(posedge clk); #1;
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 4'd0;
      snp_valid = 1'b1; snp_cmd = 2'd2; snp_addr = 4'd0;
      #3;
      chk("R10", "ack held under snoop", int'(cpu_ack), 0);
      chk("R10", "snoop flushes first", int'(snp_flush), 1);
      mem[0] = m_data[0]; m_st[0] = 0;
      @(posedge clk); #1;
      snp_valid = 1'b0;
      #3;
      chk("R10", "request sees new state", int'(bus_req) * 4 + int'(bus_cmd), 5);
      @(posedge clk); #1 cpu_req = 1'b0;

      // R10: snoop to another line delays a hit by one cycle
      access(1'b0, 4'd0, 8'h00);
      @(posedge clk); #1;
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 4'd0;
      snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 4'd6;
      #3;
      chk("R10", "ack delayed", int'(cpu_ack), 0);
      @(posedge clk); #1;
      snp_valid = 1'b0;
      #3;
      chk("R10", "ack after snoop", int'(cpu_ack), 1);
      chk("R11", "rdata after snoop", int'(cpu_rdata), int'(m_data[0]));
      @(posedge clk); #1 cpu_req = 1'b0;

      // pseudo-random sweep over all addresses, events and states
      for (int n = 0; n < 3000; n++) begin
         seed = seed * 1103515245 + 12345;
         case ((seed >>> 16) & 3)
            0, 1: access(1'b0, AW'(seed >>> 20), 8'h00);
            2:    access(1'b1, AW'(seed >>> 20), DW'(seed >>> 8));
            default: snoop(((seed >>> 24) & 1) == 1, AW'(seed >>> 20));
         endcase
      end

      summary();
      $finish;
   end
endmodule